// File: doc/BRIEF.md
# Audio Playback Sample FIFO with DMA Pacing

This block buffers playback samples between a DMA engine and the digital datapath of a stereo audio DAC. Software and DMA reach it through four 32-bit, word-aligned registers: a control word, a status word, a write-only data port and a running count of consumed samples. Each word written to the data port is turned into a 24-bit sample as it enters the FIFO. The input can be a 16-bit sample or a 24-bit sample carried in the upper part of a 32-bit word. A 16-bit sample is widened either by appending zero low bits or by sign-extending its top bit.

The DAC side presents a one-cycle sample strobe. On each strobe the block hands over one left/right pair. In stereo it takes two FIFO entries, the left channel first. In mono it takes a single entry and drives it on both channels. When the FIFO cannot supply the pair, the block counts this as an underrun. It then drives silence or repeats the previous pair, as software has selected, and latches a sticky flag. A DMA request is raised when free space reaches a programmable set level. It is dropped only when free space falls below a separate, coarser clear level, so that DMA bursts are not cut short by a single-entry change.

Top module: `dac_txfifo_ctrl`

## Requirements
- R1: After reset the FIFO is empty, status reports free = DEPTH (64 by default) with the underrun flag and request bits at 0, the control and counter registers read 0, and dma_req, dac_left and dac_right are 0.
- R2: Control at 0x04 holds flush (bit 0), request enable (bit 4), 24-bit width (bit 5), mono (bit 6), set level (bits 13:8), clear code (bits 22:21), sign-fill (bit 24) and hold-last (bit 26). All other bits, including flush, read back as 0.
- R3: Each write to 0x0C stores one sample and reduces the free count (status bits 15:0) by one. A write while the FIFO is full is dropped and leaves the contents unchanged.
- R4: Writing control with bit 0 set empties the FIFO in that same cycle, so free returns to DEPTH.
- R5: While request enable is 0, dma_req is 0 from the following cycle on, whatever the fill level.
- R6: With enable set, dma_req rises one cycle after free >= set level. It falls one cycle after free < clear limit, where clear codes 0, 1, 2 and 3 give limits 2, 4, 8 and 16. Between the two levels it holds its value, and when both conditions are true the set level wins.
- R7: In 16-bit mode the sample is the low 16 bits of the word. With sign-fill 0 it becomes {s, 8'h00}; with sign-fill 1 it becomes {8 copies of s[15], s}.
- R8: In 24-bit mode the sample is word bits 31:8, and sign-fill has no effect.
- R9: In stereo, a strobe with at least two entries stored removes two entries and drives the older one on dac_left and the newer one on dac_right. The outputs change at the clock edge that samples the strobe.
- R10: In mono, a strobe with at least one entry stored removes one entry and drives it on both channels.
- R11: A strobe that finds fewer entries than the mode needs removes nothing. With hold-last 0 both outputs become 0; with hold-last 1 both outputs keep their previous values.
- R12: An underrun sets status bit 16. The bit stays set until a status write with bit 16 at 1 clears it. Status bit 17 mirrors dma_req.
- R13: The counter at 0x30 increases by the number of entries removed: 1 per mono pair, 2 per stereo pair, 0 on underrun. Flush does not reset it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data is valid in the same cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when no read is in progress |
| dma_req | output | 1 | DMA request level |
| smp_strobe | input | 1 | DAC request for one left/right pair |
| dac_left | output | 24 | Left channel sample |
| dac_right | output | 24 | Right channel sample |

## Verification
The in-line assertions watch, on every cycle, that the fill level stays inside 0..DEPTH, that a removal never exceeds what is stored, that a flush empties the FIFO and that a write to a full FIFO is dropped. They also check that the request only rises above the set level, only falls below the clear limit and stays low while disabled, that an underrun sets the sticky flag, and that silence or channel duplication follows the selected mode. Only the bench scenarios can show the values themselves: the exact widened sample for every width and fill mode, left/right ordering across several pairs, the request edge for every clear code and a range of set levels across a full fill and drain, and the consumed-sample total.

// File: rtl/txf_pkg.sv
package txf_pkg;

  // Register byte offsets; software decodes these.
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_DATA = 8'h0C;
  localparam logic [7:0] OFS_CNT  = 8'h30;

  localparam int STAT_UR_BIT  = 16;
  localparam int STAT_REQ_BIT = 17;
  localparam int SAMPLE_W     = 24;

  typedef struct packed {
    logic       hold_last;
    logic       fill_msb;
    logic [1:0] clr_code;
    logic [5:0] trig;
    logic       mono;
    logic       wide;
    logic       drq_en;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.hold_last = w[26];
    c.fill_msb  = w[24];
    c.clr_code  = w[22:21];
    c.trig      = w[13:8];
    c.mono      = w[6];
    c.wide      = w[5];
    c.drq_en    = w[4];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[26]    = c.hold_last;
    w[24]    = c.fill_msb;
    w[22:21] = c.clr_code;
    w[13:8]  = c.trig;
    w[6]     = c.mono;
    w[5]     = c.wide;
    w[4]     = c.drq_en;
    return w;
  endfunction

  // Turn a bus word into a 24-bit sample.
  function automatic logic [SAMPLE_W-1:0] widen_sample(input logic [31:0] w,
                                                       input logic wide,
                                                       input logic fill_msb);
    if (wide)          return w[31:8];
    else if (fill_msb) return {{8{w[15]}}, w[15:0]};
    else               return {w[15:0], 8'h00};
  endfunction

  // Free-space limit below which the request drops.
  function automatic int unsigned clear_limit(input logic [1:0] code);
    return 32'd2 << code;
  endfunction

endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter  int DEPTH  = 64,   // power of two
  parameter  int DATA_W = 24,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [1:0]        pop_n,
  output logic [DATA_W-1:0] head0,
  output logic [DATA_W-1:0] head1,
  output logic [CNT_W-1:0]  level
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, rd_ptr_nx;
  logic              is_full, push_ok;

  assign is_full   = (level == CNT_W'(DEPTH));
  assign push_ok   = push && !is_full;
  assign rd_ptr_nx = rd_ptr + 1'b1;
  assign head0     = mem[rd_ptr];
  assign head1     = mem[rd_ptr_nx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + ADDR_W'(pop_n);
      level  <= level + CNT_W'(push_ok) - CNT_W'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= push_data;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));
  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(pop_n) <= level);
  // R4
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0);
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && is_full && pop_n == 2'd0 && !flush) |=> level == CNT_W'(DEPTH));

endmodule

// File: rtl/txf_drq.sv
module txf_drq import txf_pkg::*; #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [5:0]       trig,
  input  logic [1:0]       clr_code,
  input  logic [CNT_W-1:0] free,
  output logic             drq
);

  int unsigned free_u;
  logic        at_set, below_clr, drq_nx;

  assign free_u    = free;
  assign at_set    = free_u >= 32'(trig);
  assign below_clr = free_u < clear_limit(clr_code);

  always_comb begin
    if (!en)           drq_nx = 1'b0;
    else if (at_set)   drq_nx = 1'b1;
    else if (below_clr) drq_nx = 1'b0;
    else               drq_nx = drq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drq <= 1'b0;
    else        drq <= drq_nx;
  end

  // R5
  drq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !drq);
  // R6
  drq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq) |-> 32'($past(free)) >= 32'($past(trig)));
  // R6
  drq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drq) |-> (!$past(en) ||
                    32'($past(free)) < (32'd2 << $past(clr_code))));

endmodule

// File: rtl/txf_out.sv
module txf_out #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              mono,
  input  logic              hold_last,
  input  logic [CNT_W-1:0]  level,
  input  logic [DATA_W-1:0] head0,
  input  logic [DATA_W-1:0] head1,
  output logic [1:0]        pop_n,
  output logic              underrun_evt,
  output logic [DATA_W-1:0] left,
  output logic [DATA_W-1:0] right
);

  logic [1:0] need;
  logic       served;

  assign need         = mono ? 2'd1 : 2'd2;
  assign served       = strobe && (level >= CNT_W'(need));
  assign underrun_evt = strobe && !served;
  assign pop_n        = served ? need : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left  <= '0;
      right <= '0;
    end else if (served) begin
      left  <= head0;
      right <= mono ? head0 : head1;
    end else if (underrun_evt && !hold_last) begin
      left  <= '0;
      right <= '0;
    end
  end

  // R11
  silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_evt && !hold_last) |=> (left == '0 && right == '0));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_evt && hold_last) |=> ($stable(left) && $stable(right)));
  // R10
  mono_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mono && pop_n != 2'd0) |=> left == right);

endmodule

// File: rtl/txf_regs.sv
module txf_regs import txf_pkg::*; #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             underrun_evt,
  input  logic [1:0]       pop_n,
  input  logic [CNT_W-1:0] free,
  input  logic             drq,
  output ctrl_t            ctrl,
  output logic             flush_evt,
  output logic             push_evt,
  output logic [31:0]      bus_rdata
);

  logic        wr_ctrl, ur_clr, ur_flag;
  logic [31:0] tx_count;
  logic [31:0] stat_word;

  assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
  assign flush_evt = wr_ctrl && bus_wdata[0];
  assign push_evt  = bus_wr && (bus_addr == OFS_DATA);
  assign ur_clr    = bus_wr && (bus_addr == OFS_STAT) && bus_wdata[STAT_UR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      ur_flag  <= 1'b0;
      tx_count <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_from_word(bus_wdata);
      if (underrun_evt)  ur_flag <= 1'b1;
      else if (ur_clr)   ur_flag <= 1'b0;
      tx_count <= tx_count + 32'(pop_n);
    end
  end

  always_comb begin
    stat_word               = '0;
    stat_word[CNT_W-1:0]    = free;
    stat_word[STAT_UR_BIT]  = ur_flag;
    stat_word[STAT_REQ_BIT] = drq;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_CTRL: bus_rdata = ctrl_to_word(ctrl);
        OFS_STAT: bus_rdata = stat_word;
        OFS_CNT:  bus_rdata = tx_count;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R12
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> ur_flag);
  // R12
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ur_clr && !underrun_evt) |=> !ur_flag);
  // R13
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_n == 2'd0 |=> $stable(tx_count));

endmodule

// File: rtl/dac_txfifo_ctrl.sv
module dac_txfifo_ctrl import txf_pkg::*; #(
  parameter  int DEPTH = 64,   // power of two, at most 32768
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                dma_req,
  input  logic                smp_strobe,
  output logic [SAMPLE_W-1:0] dac_left,
  output logic [SAMPLE_W-1:0] dac_right
);

  ctrl_t                ctrl;
  logic                 flush_evt, push_evt, underrun_evt;
  logic [1:0]           pop_n;
  logic [CNT_W-1:0]     level, free;
  logic [SAMPLE_W-1:0]  push_sample, head0, head1;

  assign free        = CNT_W'(DEPTH) - level;
  assign push_sample = widen_sample(bus_wdata, ctrl.wide, ctrl.fill_msb);

  txf_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .underrun_evt(underrun_evt), .pop_n(pop_n), .free(free), .drq(dma_req),
    .ctrl(ctrl), .flush_evt(flush_evt), .push_evt(push_evt),
    .bus_rdata(bus_rdata)
  );

  txf_store #(.DEPTH(DEPTH), .DATA_W(SAMPLE_W)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_evt), .push(push_evt),
    .push_data(push_sample), .pop_n(pop_n),
    .head0(head0), .head1(head1), .level(level)
  );

  txf_drq #(.CNT_W(CNT_W)) drq_i (
    .clk(clk), .rst_n(rst_n), .en(ctrl.drq_en), .trig(ctrl.trig),
    .clr_code(ctrl.clr_code), .free(free), .drq(dma_req)
  );

  txf_out #(.DATA_W(SAMPLE_W), .CNT_W(CNT_W)) out_i (
    .clk(clk), .rst_n(rst_n), .strobe(smp_strobe), .mono(ctrl.mono),
    .hold_last(ctrl.hold_last), .level(level), .head0(head0), .head1(head1),
    .pop_n(pop_n), .underrun_evt(underrun_evt),
    .left(dac_left), .right(dac_right)
  );

  // R1
  free_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free <= CNT_W'(DEPTH));

endmodule

// File: tb/dac_txfifo_ctrl_tb.sv
module dac_txfifo_ctrl_tb_top;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, smp_strobe = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        dma_req;
  logic [23:0] dac_left, dac_right;

  int checks = 0;
  int errors = 0;
  int tally  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dac_txfifo_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .smp_strobe(smp_strobe),
    .dac_left(dac_left), .dac_right(dac_right)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    smp_strobe = 1'b1;
    @(negedge clk);
    smp_strobe = 1'b0;
  endtask

  // Control word built from the R2 field positions.
  function automatic logic [31:0] mk(input bit fl, input bit en, input bit wide,
                                     input bit mono, input int trig, input int clr,
                                     input bit fill, input bit hold);
    return (32'(fl)) | (32'(en) << 4) | (32'(wide) << 5) | (32'(mono) << 6) |
           ((32'(trig) & 32'h3F) << 8) | ((32'(clr) & 32'h3) << 21) |
           (32'(fill) << 24) | (32'(hold) << 26);
  endfunction

  function automatic logic [23:0] exp_sample(input logic [31:0] w, input bit wide, input bit fill);
    logic [23:0] s;
    if (wide) s = w >> 8;
    else if (fill) s = 24'(signed'(w[15:0]));
    else s = 24'(w[15:0]) * 24'd256;
    return s;
  endfunction

  task automatic check_free(input string req, input int exp);
    logic [31:0] d;
    rd(8'h08, d);
    check(req, d & 32'hFFFF, 32'(exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h08, d);  check("R1 status", d, 32'(DEPTH));
    rd(8'h04, d);  check("R1 ctrl", d, 32'h0);
    rd(8'h30, d);  check("R1 counter", d, 32'h0);
    check("R1 dma_req", 32'(dma_req), 32'h0);
    check("R1 outputs", {8'h0, dac_left | dac_right}, 32'h0);

    // R2 control readback
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d);  check("R2 ctrl mask", d, 32'h0560_3F70);
    wr(8'h04, mk(1, 0, 0, 0, 0, 0, 0, 0));
    rd(8'h04, d);  check("R2 flush reads 0", d, 32'h0);

    // R7 R8 R10 widening sweep in mono
    for (int m = 0; m < 4; m++) begin
      wr(8'h04, mk(1, 0, m[1], 1, 0, 0, m[0], 0));
      for (int i = 0; i < 8; i++) begin
        logic [31:0] p;
        logic [23:0] e;
        p = (32'h1357_9BDF * 32'(i + 3)) ^ (32'(i) << 15);
        e = exp_sample(p, m[1], m[0]);
        wr(8'h0C, p);
        strobe();
        tally += 1;
        check(m[1] ? "R8 wide left" : "R7 narrow left", {8'h0, dac_left}, {8'h0, e});
        check("R10 mono right", {8'h0, dac_right}, {8'h0, e});
      end
    end
    check_free("R10 drained", DEPTH);

    // R9 stereo order
    wr(8'h04, mk(1, 0, 1, 0, 0, 0, 0, 0));
    for (int i = 0; i < 4; i++) wr(8'h0C, 32'(i + 1) << 12);
    check_free("R3 four stored", DEPTH - 4);
    strobe();
    check("R9 left A", {8'h0, dac_left}, 32'h10);
    check("R9 right B", {8'h0, dac_right}, 32'h20);
    strobe();
    check("R9 left C", {8'h0, dac_left}, 32'h30);
    check("R9 right D", {8'h0, dac_right}, 32'h40);
    tally += 4;

    // R11 R12 underrun, silence
    strobe();
    check("R11 silence", {8'h0, dac_left | dac_right}, 32'h0);
    rd(8'h08, d);  check("R12 flag set", 32'(d[16]), 32'h1);
    wr(8'h08, 32'h0);
    rd(8'h08, d);  check("R12 write 0 keeps", 32'(d[16]), 32'h1);
    wr(8'h08, 32'h0001_0000);
    rd(8'h08, d);  check("R12 w1c", 32'(d[16]), 32'h0);

    // R11 hold-last
    wr(8'h04, mk(0, 0, 1, 0, 0, 0, 0, 1));
    wr(8'h0C, 32'h00AB_CD00);
    wr(8'h0C, 32'h0012_3400);
    strobe();
    tally += 2;
    strobe();
    check("R11 hold left", {8'h0, dac_left}, 32'h00AB_CD);
    check("R11 hold right", {8'h0, dac_right}, 32'h0012_34);
    wr(8'h0C, 32'h0077_7700);
    strobe();
    check("R11 single entry kept", {8'h0, dac_left}, 32'h00AB_CD);
    check_free("R11 no removal", DEPTH - 1);

    // R4 flush
    wr(8'h04, mk(1, 0, 1, 0, 0, 0, 0, 0));
    check_free("R4 flush", DEPTH);

    // R3 full drop
    for (int i = 0; i <= DEPTH; i++) wr(8'h0C, 32'(i) << 8);
    check_free("R3 full", 0);
    for (int i = 0; i < DEPTH / 2; i++) strobe();
    tally += DEPTH;
    check("R3 last left", {8'h0, dac_left}, 32'(DEPTH - 2));
    check("R3 last right", {8'h0, dac_right}, 32'(DEPTH - 1));
    check_free("R3 drained", DEPTH);

    // R5 gate
    wr(8'h04, mk(1, 0, 1, 0, 1, 0, 0, 0));
    @(negedge clk);
    check("R5 disabled", 32'(dma_req), 32'h0);

    // R6 sweep over clear codes and set levels
    for (int c = 0; c < 4; c++) begin
      for (int t = 0; t < 4; t++) begin
        int trig;
        int lim;
        bit q;
        trig = (t == 0) ? 1 : (t == 1) ? 12 : (t == 2) ? 33 : 63;
        lim = 2 << c;
        q = 1'b0;
        wr(8'h04, mk(1, 1, 1, 0, trig, c, 0, 0));
        @(negedge clk);
        q = 1'b1;
        check("R6 start", 32'(dma_req), 32'(q));
        for (int k = 1; k <= DEPTH; k++) begin
          int fr;
          wr(8'h0C, 32'(k) << 8);
          @(negedge clk);
          fr = DEPTH - k;
          if (fr >= trig) q = 1'b1; else if (fr < lim) q = 1'b0;
          check("R6 fill", 32'(dma_req), 32'(q));
        end
        for (int k = 1; k <= DEPTH / 2; k++) begin
          int fr;
          strobe();
          @(negedge clk);
          fr = 2 * k;
          if (fr >= trig) q = 1'b1; else if (fr < lim) q = 1'b0;
          check("R6 drain", 32'(dma_req), 32'(q));
        end
        tally += DEPTH;
        rd(8'h08, d);  check("R12 req mirror", 32'(d[17]), 32'(dma_req));
      end
    end

    // R13 counter
    wr(8'h04, mk(1, 0, 0, 0, 0, 0, 0, 0));
    rd(8'h30, d);  check("R13 counter", d, 32'(tally));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule